// File: doc/BRIEF.md
# Bus release handshake controller

This block hands a 24-bit external memory bus to an outside master and takes it back. The outside master asks for the bus by pulling an active-low request low. The controller waits until the internal bus master is between cycles and the external wait line is inactive. It then turns off the output enables of every bus pin group and, after a fixed gap, pulls the active-low acknowledge low. When the request goes high again, the order is reversed: acknowledge goes high first, and the enables come back after the same gap.

While a request is pending, and for the whole time the bus is away, a stall output holds off the internal master. The request and wait inputs come from outside the clock domain, so they pass through a synchroniser chain before they are used. The busy flag from the internal master is already synchronous and is used as it arrives. While the bus is released, the outside master reaches only external memory. Nothing inside the chip is reachable through this handshake.

Top module: `bus_release_ctrl`

## Requirements
- R1: After reset, back_no is 1, every address, strobe and chip-select enable is 1, and stall_o is 0.
- R2: With wait_ni high and cyc_busy_i low, a fall of breq_ni turns off all output enables exactly SYNC_STAGES+1 clock edges later. The enables are still on one edge earlier.
- R3: back_no falls exactly GAP_CYC edges after the enables turn off. back_no is never 0 while any enable is 1.
- R4: While the synchronised wait_ni is 0, no release starts. Once wait_ni rises with the request still pending, the enables turn off SYNC_STAGES+1 edges later.
- R5: While cyc_busy_i is 1, no release starts. The enables turn off on the first edge at which cyc_busy_i is 0.
- R6: stall_o is 1 from the edge at which the synchronised request is seen until the enables are restored.
- R7: On a rise of breq_ni, back_no rises SYNC_STAGES+1 edges later. The enables return exactly GAP_CYC edges after that.
- R8: If the request is withdrawn while the enables are off but before acknowledge has fallen, the enables return and back_no never goes low.
- R9: data_oe_o equals data_drive_i on every bit while the bus is owned internally, and is all 0 whenever the enables are off, regardless of data_drive_i.
- R10: Once acknowledge is low, changes on wait_ni have no effect: back_no stays 0 and the enables stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| breq_ni | input | 1 | External bus request, active low, asynchronous |
| wait_ni | input | 1 | External wait, active low, asynchronous |
| cyc_busy_i | input | 1 | Internal master has a bus cycle in progress |
| data_drive_i | input | 1 | Internal master wants the data pins driven |
| back_no | output | 1 | Bus acknowledge, active low |
| stall_o | output | 1 | Holds off new internal bus cycles |
| addr_oe_o | output | ADDR_W | Address pin output enables |
| data_oe_o | output | DATA_W | Data pin output enables |
| strb_oe_o | output | 3 | Read, write and high-write strobe enables |
| cs_oe_o | output | CS_N | Chip-select output enables |

## Verification
The bench builds the block with GAP_CYC=3 and SYNC_STAGES=2, with the default bus widths. A gap of three makes the counter pass through several values in both the float and the reclaim phases, so an off-by-one in either phase shows up as a wrong edge count. The bench also covers three other cases: a release held back by wait, a release held back by a busy cycle, and a request pulse short enough that it is withdrawn during the float phase and takes the abort path.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    BS_OWN   = 2'd0,
    BS_FLOAT = 2'd1,
    BS_REL   = 2'd2,
    BS_RECL  = 2'd3
  } bus_st_e;
endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
  parameter int unsigned        WIDTH   = 2,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/brc_fsm.sv
module brc_fsm import brc_pkg::*; #(
  parameter int unsigned GAP_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,      // synchronised request, active high
  input  logic wait_ok_i,  // synchronised wait inactive
  input  logic busy_i,
  output logic own_o,
  output logic ack_o,
  output logic stall_o
);
  localparam int unsigned CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYC - 1);

  bus_st_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gap_done;

  assign gap_done = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BS_OWN:   if (req_i && wait_ok_i && !busy_i) state_d = BS_FLOAT;
      BS_FLOAT: if (!req_i)        state_d = BS_OWN;  // abort, no ack seen
                else if (gap_done) state_d = BS_REL;
      BS_REL:   if (!req_i)        state_d = BS_RECL;
      BS_RECL:  if (gap_done)      state_d = BS_OWN;
      default:                     state_d = BS_OWN;
    endcase
  end

  always_comb begin
    if (state_d != state_q)                             cnt_d = '0;
    else if ((state_q == BS_FLOAT || state_q == BS_RECL) && !gap_done)
                                                        cnt_d = cnt_q + 1'b1;
    else                                                cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BS_OWN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign own_o   = (state_q == BS_OWN);
  assign ack_o   = (state_q == BS_REL);
  assign stall_o = req_i || (state_q != BS_OWN);
endmodule

// File: rtl/brc_oe_fan.sv
module brc_oe_fan #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CS_N   = 4
) (
  input  logic              own_i,
  input  logic              data_drive_i,
  output logic [ADDR_W-1:0] addr_oe_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic [2:0]        strb_oe_o,
  output logic [CS_N-1:0]   cs_oe_o
);
  assign addr_oe_o = {ADDR_W{own_i}};
  assign data_oe_o = {DATA_W{own_i & data_drive_i}};
  assign strb_oe_o = {3{own_i}};
  assign cs_oe_o   = {CS_N{own_i}};
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CS_N        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GAP_CYC     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              breq_ni,
  input  logic              wait_ni,
  input  logic              cyc_busy_i,
  input  logic              data_drive_i,
  output logic              back_no,
  output logic              stall_o,
  output logic [ADDR_W-1:0] addr_oe_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic [2:0]        strb_oe_o,
  output logic [CS_N-1:0]   cs_oe_o
);
  logic [1:0] pins_s;
  logic       own, ack;

  brc_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({breq_ni, wait_ni}),
    .q_o   (pins_s)
  );

  brc_fsm #(
    .GAP_CYC(GAP_CYC)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (~pins_s[1]),
    .wait_ok_i(pins_s[0]),
    .busy_i   (cyc_busy_i),
    .own_o    (own),
    .ack_o    (ack),
    .stall_o  (stall_o)
  );

  brc_oe_fan #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CS_N  (CS_N)
  ) u_fan (
    .own_i       (own),
    .data_drive_i(data_drive_i),
    .addr_oe_o   (addr_oe_o),
    .data_oe_o   (data_oe_o),
    .strb_oe_o   (strb_oe_o),
    .cs_oe_o     (cs_oe_o)
  );

  assign back_no = ~ack;
endmodule

// File: rtl/bus_release_ctrl_chk.sv
module bus_release_ctrl_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CS_N   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_busy_i,
  input logic              back_no,
  input logic              stall_o,
  input logic [ADDR_W-1:0] addr_oe_o,
  input logic [DATA_W-1:0] data_oe_o,
  input logic [2:0]        strb_oe_o,
  input logic [CS_N-1:0]   cs_oe_o
);
  logic any_oe;
  assign any_oe = (|addr_oe_o) || (|data_oe_o) || (|strb_oe_o) || (|cs_oe_o);

  a_r3_ack_only_floated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !back_no |-> !any_oe);

  a_r3_float_before_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(back_no) |-> $past(addr_oe_o == '0));

  a_r7_ack_high_before_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_oe_o[0]) |-> ($past(back_no) && back_no));

  a_r5_release_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_oe_o[0]) |-> $past(!cyc_busy_i));

  a_r6_stall_while_away: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_oe_o == '0) |-> stall_o);

  a_r9_no_data_when_floated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_oe_o == '0) |-> (data_oe_o == '0));
endmodule

bind bus_release_ctrl bus_release_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CS_N  (CS_N)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cyc_busy_i(cyc_busy_i),
  .back_no   (back_no),
  .stall_o   (stall_o),
  .addr_oe_o (addr_oe_o),
  .data_oe_o (data_oe_o),
  .strb_oe_o (strb_oe_o),
  .cs_oe_o   (cs_oe_o)
);

// File: tb/bus_release_ctrl_tb.sv
`timescale 1ns/100ps
module bus_release_ctrl_tb;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;
  localparam int CS_N   = 4;
  localparam int SYNC   = 2;
  localparam int GAP    = 3;

  localparam int EV_OE_OFF = 1;
  localparam int EV_ACK_LO = 2;
  localparam int EV_ACK_HI = 3;
  localparam int EV_OE_ON  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic breq_ni = 1'b1, wait_ni = 1'b1, cyc_busy_i = 1'b0, data_drive_i = 1'b0;
  logic back_no, stall_o;
  logic [ADDR_W-1:0] addr_oe_o;
  logic [DATA_W-1:0] data_oe_o;
  logic [2:0]        strb_oe_o;
  logic [CS_N-1:0]   cs_oe_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  bus_release_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_N(CS_N),
    .SYNC_STAGES(SYNC), .GAP_CYC(GAP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .breq_ni(breq_ni), .wait_ni(wait_ni),
    .cyc_busy_i(cyc_busy_i), .data_drive_i(data_drive_i),
    .back_no(back_no), .stall_o(stall_o), .addr_oe_o(addr_oe_o),
    .data_oe_o(data_oe_o), .strb_oe_o(strb_oe_o), .cs_oe_o(cs_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_oe(input string tag, input logic on);
    chk({tag, " addr_oe"}, 32'(addr_oe_o), on ? 32'({ADDR_W{1'b1}}) : 32'd0);
    chk({tag, " cs_oe"},   32'(cs_oe_o),   on ? 32'({CS_N{1'b1}})   : 32'd0);
    chk({tag, " strb_oe"}, 32'(strb_oe_o), on ? 32'd7 : 32'd0);
  endtask

  // scoreboard monitor: pops expected ordering events as the outputs move
  logic prev_oe, prev_ack_lo;
  int   since, last_ev;

  task automatic take_ev(input int code, input string tag);
    int exp;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL %s: unexpected event actual %0d expected none", tag, code);
    end else begin
      exp = exp_q.pop_front();
      if (exp != code) begin
        fails++;
        $display("FAIL %s: event actual %0d expected %0d", tag, code, exp);
      end
    end
    if ((code == EV_ACK_LO && last_ev == EV_OE_OFF) ||
        (code == EV_OE_ON && last_ev == EV_ACK_HI))
      chk({tag, " gap"}, 32'(since), 32'(GAP));
    last_ev = code;
    since   = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_oe = 1'b1; prev_ack_lo = 1'b0; since = 0; last_ev = 0;
    end else begin
      since++;
      if (prev_oe && !addr_oe_o[0])     take_ev(EV_OE_OFF, "R3 oe off");
      if (!prev_ack_lo && !back_no)     take_ev(EV_ACK_LO, "R3 ack low");
      if (prev_ack_lo && back_no)       take_ev(EV_ACK_HI, "R7 ack high");
      if (!prev_oe && addr_oe_o[0])     take_ev(EV_OE_ON,  "R7 oe on");
      prev_oe     = addr_oe_o[0];
      prev_ack_lo = !back_no;
    end
  end

  task automatic reclaim(input string tag);
    exp_q.push_back(EV_ACK_HI);
    exp_q.push_back(EV_OE_ON);
    breq_ni = 1'b1;
    step(SYNC);
    chk({tag, " ack still low"}, 32'(back_no), 32'd0);
    step(1);
    chk({tag, " ack high"}, 32'(back_no), 32'd1);
    chk_oe({tag, " still floated"}, 1'b0);
    step(GAP - 1);
    chk_oe({tag, " gap held"}, 1'b0);
    step(1);
    chk_oe({tag, " restored"}, 1'b1);
    chk({tag, " stall clear"}, 32'(stall_o), 32'd0);
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 ack", 32'(back_no), 32'd1);
    chk_oe("R1", 1'b1);
    chk("R1 stall", 32'(stall_o), 32'd0);
    data_drive_i = 1'b1;
    step(1);
    chk("R9 data follows drive", 32'(data_oe_o), 32'hFFFF);

    // R2/R3 basic release
    exp_q.push_back(EV_OE_OFF);
    exp_q.push_back(EV_ACK_LO);
    breq_ni = 1'b0;
    step(SYNC);
    chk_oe("R2 before latency", 1'b1);
    chk("R6 stall on seen request", 32'(stall_o), 32'd1);
    step(1);
    chk_oe("R2 released", 1'b0);
    chk("R3 ack waits", 32'(back_no), 32'd1);
    chk("R9 data forced off", 32'(data_oe_o), 32'd0);
    step(GAP - 1);
    chk("R3 ack gap", 32'(back_no), 32'd1);
    step(1);
    chk("R3 ack low", 32'(back_no), 32'd0);
    chk("R6 stall while away", 32'(stall_o), 32'd1);

    // R10 wait ignored after grant
    wait_ni = 1'b0;
    step(5);
    chk("R10 ack held", 32'(back_no), 32'd0);
    chk_oe("R10 oe held", 1'b0);
    wait_ni = 1'b1;
    step(2);

    reclaim("R7");
    chk("R9 data back", 32'(data_oe_o), 32'hFFFF);
    step(4);

    // R4 wait blocks release
    wait_ni = 1'b0;
    step(3);
    breq_ni = 1'b0;
    step(10);
    chk_oe("R4 blocked", 1'b1);
    chk("R6 stall pending", 32'(stall_o), 32'd1);
    exp_q.push_back(EV_OE_OFF);
    exp_q.push_back(EV_ACK_LO);
    wait_ni = 1'b1;
    step(SYNC);
    chk_oe("R4 still blocked", 1'b1);
    step(1);
    chk_oe("R4 released", 1'b0);
    step(GAP);
    chk("R4 ack low", 32'(back_no), 32'd0);
    reclaim("R7 after wait");
    step(4);

    // R5 busy cycle blocks release
    cyc_busy_i = 1'b1;
    breq_ni = 1'b0;
    step(10);
    chk_oe("R5 blocked by busy", 1'b1);
    exp_q.push_back(EV_OE_OFF);
    exp_q.push_back(EV_ACK_LO);
    cyc_busy_i = 1'b0;
    step(1);
    chk_oe("R5 released at boundary", 1'b0);
    step(GAP);
    chk("R5 ack low", 32'(back_no), 32'd0);
    reclaim("R7 after busy");
    step(4);

    // R8 abort during float
    exp_q.push_back(EV_OE_OFF);
    exp_q.push_back(EV_OE_ON);
    breq_ni = 1'b0;
    step(1);
    breq_ni = 1'b1;
    step(SYNC);
    chk_oe("R8 floated", 1'b0);
    chk("R8 ack high", 32'(back_no), 32'd1);
    step(1);
    chk_oe("R8 restored", 1'b1);
    chk("R8 ack never low", 32'(back_no), 32'd1);
    step(6);
    chk("R8 ack quiet", 32'(back_no), 32'd1);

    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule